// File: doc/BRIEF.md
# Frame-Synchronized Dot Refresh Controller

This block decides when brightness values written by a host reach the compare registers of an LED matrix's PWM stage. Each dot has a 16-bit active level that drives the PWM stage in parallel. A 2-bit configuration input picks how new values arrive. In direct mode each write lands on its dot at once and leaves every other dot as it was. In the two framed modes, writes collect in a shadow store and move to the active levels together at a qualified frame sync. One framed mode takes 8-bit values. The other takes 16-bit values assembled from two byte writes.

The frame sync input is asynchronous. It passes through a two-stage synchroniser, and its high time is counted in clock cycles. A frame event fires on the falling edge only when the high time reached a parameterised minimum, so short glitches move nothing. Each shadow entry carries a ready flag. A frame event copies only ready entries and then clears every flag. Changing the configured mode also clears the flags.

Top module: `frame_refresh_ctrl`

## Requirements
- R1: After a synchronous active-low reset, every dot level on `dot_level` is zero.
- R2: With `cfg_mode` = 2'b00 (direct), a write sets the addressed dot to {8'h00, `wr_data`} on the next clock edge and leaves every other dot unchanged.
- R3: With `cfg_mode` = 2'b01 (framed, 8-bit) or 2'b10 (framed, 16-bit), writes never change `dot_level` until a frame event occurs.
- R4: A frame event happens when `vsync_in` falls after being high for at least `MIN_SYNC_CYC` clock cycles. It updates the dot levels on the third rising clock edge after the fall.
- R5: A high pulse on `vsync_in` shorter than `MIN_SYNC_CYC` cycles causes no frame event, so no dot level changes.
- R6: In mode 2'b01 a write stores {8'h00, `wr_data`} as the dot's next value. A frame event loads only the dots written since the previous event. Dots not written keep their levels, and a second event with no writes in between changes nothing.
- R7: In mode 2'b10 a write with `wr_hi` = 0 sets a dot's low byte and marks the dot incomplete. A write with `wr_hi` = 1 sets the high byte and marks the dot complete. A frame event loads {high, low} only for complete dots.
- R8: A write accepted in the same cycle as a frame event goes into the next frame's data. The frame being loaded carries the earlier value, and the next event loads the new one.
- R9: A change of `cfg_mode` discards every shadow entry that is waiting for a frame event. A change to direct mode applies to the very next write.
- R10: The spare encoding `cfg_mode` = 2'b11 behaves as direct mode.
- R11: In the 8-bit modes (2'b00, 2'b01, 2'b11), `wr_hi` is ignored: the byte always goes to the low half, and the high half becomes zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cfg_mode | input | 2 | Refresh mode: 00 direct, 01 framed 8-bit, 10 framed 16-bit, 11 direct |
| wr_en | input | 1 | Write strobe, one cycle per byte |
| wr_addr | input | $clog2(NUM_DOTS) | Dot index of the write |
| wr_hi | input | 1 | Byte select in 16-bit mode: 1 selects the high byte |
| wr_data | input | 8 | Byte being written |
| vsync_in | input | 1 | Asynchronous frame sync, active high |
| dot_level | output | NUM_DOTS*16 | Active levels, dot i at bits [16*i+15 : 16*i] |

## Verification
The bench builds the block with `NUM_DOTS` = 8 and `MIN_SYNC_CYC` = 5. With a small dot count, every dot level can be compared after each step. With a short minimum width, sync pulses of exactly four and five cycles are cheap to produce, which tests the accept/reject boundary on both sides. The bench also times a write so that it lands on the same edge as the frame load. This shows that the ready flag is set by the write and not lost to the clear that the frame event triggers.

// File: rtl/frc_pkg.sv
// Shared encodings for the dot refresh controller.
// Assumes a 2-bit mode field; 2'b11 is spare and handled as direct mode.
package frc_pkg;
    typedef enum logic [1:0] {
        MODE_DIRECT  = 2'b00,
        MODE_FRAME8  = 2'b01,
        MODE_FRAME16 = 2'b10,
        MODE_SPARE   = 2'b11
    } refresh_mode_e;

    localparam int LVL_W  = 16;
    localparam int BYTE_W = 8;

    // True when the mode defers writes to a frame event.
    function automatic logic mode_is_framed(input logic [1:0] m);
        return (m == MODE_FRAME8) || (m == MODE_FRAME16);
    endfunction
endpackage

// File: rtl/frc_sync_qualifier.sv
// Synchronises the asynchronous frame sync and measures its high time.
// Emits a one-cycle event on the synchronised falling edge when the high
// time reached MIN_HIGH cycles. Assumes SYNC_STAGES >= 2.
module frc_sync_qualifier #(
    parameter int MIN_HIGH    = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sync_in,
    output logic frame_evt
);
    localparam int CNT_W = $clog2(MIN_HIGH + 1);
    localparam logic [CNT_W-1:0] CNT_TOP = CNT_W'(MIN_HIGH);

    logic [SYNC_STAGES-1:0] sync_pipe;
    logic                   level;
    logic                   level_d;
    logic [CNT_W-1:0]       high_cnt;

    assign level = sync_pipe[SYNC_STAGES-1];

    // Shift the raw input through the synchroniser chain.
    always_ff @(posedge clk) begin
        if (!rst_n) sync_pipe <= '0;
        else        sync_pipe <= {sync_pipe[SYNC_STAGES-2:0], sync_in};
    end

    // Keep the previous synchronised level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) level_d <= 1'b0;
        else        level_d <= level;
    end

    // Count high cycles, saturating at the minimum width.
    always_ff @(posedge clk) begin
        if (!rst_n)                high_cnt <= '0;
        else if (!level)           high_cnt <= '0;
        else if (high_cnt != CNT_TOP) high_cnt <= high_cnt + CNT_W'(1);
    end

    // Qualified falling edge.
    assign frame_evt = level_d && !level && (high_cnt == CNT_TOP);

    // R4: at most one event per pulse.
    a_r4_single_event: assert property (@(posedge clk) disable iff (!rst_n)
        frame_evt |=> !frame_evt);
endmodule

// File: rtl/frc_shadow_store.sv
// Holds the next-frame value of every dot plus a ready flag per dot.
// A flush clears all ready flags; a write in the same cycle wins for its dot.
// Assumes wr_addr < NUM_DOTS.
module frc_shadow_store
    import frc_pkg::*;
#(
    parameter int NUM_DOTS = 16,
    parameter int AW       = $clog2(NUM_DOTS)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      wr_en,
    input  logic [AW-1:0]             wr_addr,
    input  logic                      wr_hi,
    input  logic [BYTE_W-1:0]         wr_data,
    input  logic                      wide,
    input  logic                      flush,
    output logic [NUM_DOTS*LVL_W-1:0] shadow_flat,
    output logic [NUM_DOTS-1:0]       ready
);
    for (genvar g = 0; g < NUM_DOTS; g++) begin : g_entry
        logic hit;
        logic [LVL_W-1:0] val;
        assign hit = wr_en && (wr_addr == AW'(g));
        assign shadow_flat[g*LVL_W +: LVL_W] = val;

        // Update one shadow entry and its ready flag.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                val      <= '0;
                ready[g] <= 1'b0;
            end else if (hit) begin
                if (wide && wr_hi) begin
                    val[LVL_W-1:BYTE_W] <= wr_data;
                    ready[g]            <= 1'b1;
                end else if (wide) begin
                    val[BYTE_W-1:0] <= wr_data;
                    ready[g]        <= 1'b0;
                end else begin
                    val      <= {{(LVL_W-BYTE_W){1'b0}}, wr_data};
                    ready[g] <= 1'b1;
                end
            end else if (flush) begin
                ready[g] <= 1'b0;
            end
        end
    end

    // R8: a completing write survives a simultaneous flush.
    a_r8_write_survives_flush: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && flush && (!wide || wr_hi)) |=> ready[$past(wr_addr)]);

    // R7: a low byte alone leaves the dot incomplete.
    a_r7_low_byte_incomplete: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wide && !wr_hi) |=> !ready[$past(wr_addr)]);
endmodule

// File: rtl/frc_active_store.sv
// Active per-dot levels seen by the PWM stage.
// A direct write sets one dot; a load copies every ready shadow entry.
// Assumes direct writes and loads are never requested together by the top.
module frc_active_store
    import frc_pkg::*;
#(
    parameter int NUM_DOTS = 16,
    parameter int AW       = $clog2(NUM_DOTS)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      direct_en,
    input  logic [AW-1:0]             wr_addr,
    input  logic [BYTE_W-1:0]         wr_data,
    input  logic                      load,
    input  logic [NUM_DOTS-1:0]       ready,
    input  logic [NUM_DOTS*LVL_W-1:0] shadow_flat,
    output logic [NUM_DOTS*LVL_W-1:0] level_flat
);
    for (genvar g = 0; g < NUM_DOTS; g++) begin : g_dot
        logic [LVL_W-1:0] lvl;
        assign level_flat[g*LVL_W +: LVL_W] = lvl;

        // Update one active level.
        always_ff @(posedge clk) begin
            if (!rst_n)
                lvl <= '0;
            else if (direct_en && (wr_addr == AW'(g)))
                lvl <= {{(LVL_W-BYTE_W){1'b0}}, wr_data};
            else if (load && ready[g])
                lvl <= shadow_flat[g*LVL_W +: LVL_W];
        end
    end
endmodule

// File: rtl/frame_refresh_ctrl.sv
// Top of the dot refresh controller. Routes writes to the active levels
// (direct mode) or the shadow store (framed modes) and loads the shadow
// store at each qualified frame event. Assumes wr_addr < NUM_DOTS.
module frame_refresh_ctrl
    import frc_pkg::*;
#(
    parameter int NUM_DOTS     = 16,
    parameter int MIN_SYNC_CYC = 8
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic [1:0]                        cfg_mode,
    input  logic                              wr_en,
    input  logic [$clog2(NUM_DOTS)-1:0]       wr_addr,
    input  logic                              wr_hi,
    input  logic [7:0]                        wr_data,
    input  logic                              vsync_in,
    output logic [NUM_DOTS*16-1:0]            dot_level
);
    localparam int AW = $clog2(NUM_DOTS);

    logic                      framed;
    logic                      wide;
    logic [1:0]                mode_seen;
    logic                      mode_chg;
    logic                      frame_evt;
    logic                      xfer;
    logic                      flush;
    logic [NUM_DOTS*LVL_W-1:0] shadow_flat;
    logic [NUM_DOTS-1:0]       ready;

    assign framed   = mode_is_framed(cfg_mode);
    assign wide     = (cfg_mode == MODE_FRAME16);
    assign mode_chg = (cfg_mode != mode_seen);
    assign xfer     = frame_evt && framed;
    assign flush    = xfer || mode_chg;

    // Remember the last mode to spot changes.
    always_ff @(posedge clk) begin
        if (!rst_n) mode_seen <= MODE_DIRECT;
        else        mode_seen <= cfg_mode;
    end

    frc_sync_qualifier #(
        .MIN_HIGH    (MIN_SYNC_CYC),
        .SYNC_STAGES (2)
    ) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .sync_in   (vsync_in),
        .frame_evt (frame_evt)
    );

    frc_shadow_store #(.NUM_DOTS(NUM_DOTS), .AW(AW)) u_shadow (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (wr_en && framed),
        .wr_addr     (wr_addr),
        .wr_hi       (wr_hi),
        .wr_data     (wr_data),
        .wide        (wide),
        .flush       (flush),
        .shadow_flat (shadow_flat),
        .ready       (ready)
    );

    frc_active_store #(.NUM_DOTS(NUM_DOTS), .AW(AW)) u_active (
        .clk         (clk),
        .rst_n       (rst_n),
        .direct_en   (wr_en && !framed),
        .wr_addr     (wr_addr),
        .wr_data     (wr_data),
        .load        (xfer),
        .ready       (ready),
        .shadow_flat (shadow_flat),
        .level_flat  (dot_level)
    );

    // R3: levels move only on a load or a direct write.
    a_r3_hold_between_frames: assert property (@(posedge clk) disable iff (!rst_n)
        (!xfer && !(wr_en && !framed)) |=> $stable(dot_level));

    // R2: a direct write is visible one edge later.
    a_r2_direct_visible: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !framed) |=>
            (dot_level[$past(wr_addr)*LVL_W +: LVL_W] == {8'h00, $past(wr_data)}));

    // R9: a mode change with no write discards all pending entries.
    a_r9_mode_change_drops: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_chg && !wr_en) |=> (ready == '0));
endmodule

// File: tb/frame_refresh_ctrl_test.sv
// Directed bench: one task per scenario, each checking all dot levels.
module frame_refresh_ctrl_test;
    localparam int N    = 8;
    localparam int MINW = 5;
    localparam int AW   = $clog2(N);

    logic          clk = 1'b0;
    logic          rst_n;
    logic [1:0]    cfg_mode;
    logic          wr_en;
    logic [AW-1:0] wr_addr;
    logic          wr_hi;
    logic [7:0]    wr_data;
    logic          vsync_in;
    logic [N*16-1:0] dot_level;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;
    logic [15:0] exp_lvl [N];

    always #5 clk = ~clk;

    frame_refresh_ctrl #(.NUM_DOTS(N), .MIN_SYNC_CYC(MINW)) uut (
        .clk(clk), .rst_n(rst_n), .cfg_mode(cfg_mode), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_hi(wr_hi), .wr_data(wr_data),
        .vsync_in(vsync_in), .dot_level(dot_level)
    );

    function automatic logic [15:0] lvl_of(input int i);
        return dot_level[i*16 +: 16];
    endfunction

    task automatic check_all(input string req);
        for (int i = 0; i < N; i++) begin
            n_chk++;
            if (lvl_of(i) !== exp_lvl[i]) begin
                n_bad++;
                $display("FAIL %s dot %0d actual %h expected %h", req, i, lvl_of(i), exp_lvl[i]);
            end
        end
    endtask

    task automatic wr(input int a, input bit hi, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = AW'(a); wr_hi = hi; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic set_mode(input logic [1:0] m);
        @(negedge clk);
        cfg_mode = m;
        repeat (2) @(negedge clk);
    endtask

    task automatic vs_pulse(input int len);
        @(negedge clk);
        vsync_in = 1'b1;
        repeat (len) @(negedge clk);
        vsync_in = 1'b0;
        repeat (5) @(negedge clk);
    endtask

    task automatic t_reset;
        for (int i = 0; i < N; i++) exp_lvl[i] = 16'h0000;
        check_all("R1");
    endtask

    task automatic t_direct;
        set_mode(2'b00);
        wr(2, 1'b0, 8'h5A); exp_lvl[2] = 16'h005A;
        check_all("R2");
        wr(3, 1'b1, 8'h77); exp_lvl[3] = 16'h0077;
        check_all("R11");
        wr(2, 1'b0, 8'hC3); exp_lvl[2] = 16'h00C3;
        check_all("R2");
    endtask

    task automatic t_spare;
        set_mode(2'b11);
        wr(4, 1'b0, 8'h33); exp_lvl[4] = 16'h0033;
        check_all("R10");
    endtask

    task automatic t_frame8;
        set_mode(2'b01);
        wr(2, 1'b0, 8'hA1);
        wr(5, 1'b1, 8'h11);
        check_all("R3");
        vs_pulse(MINW - 1);
        check_all("R5");
        vs_pulse(1);
        check_all("R5");
        vs_pulse(MINW);
        exp_lvl[2] = 16'h00A1; exp_lvl[5] = 16'h0011;
        check_all("R4");
        vs_pulse(MINW + 3);
        check_all("R6");
    endtask

    task automatic t_frame16;
        set_mode(2'b10);
        wr(1, 1'b0, 8'h34);
        wr(1, 1'b1, 8'h12);
        wr(6, 1'b0, 8'h99);
        check_all("R3");
        vs_pulse(MINW);
        exp_lvl[1] = 16'h1234;
        check_all("R7");
        wr(6, 1'b1, 8'h88);
        vs_pulse(MINW);
        exp_lvl[6] = 16'h8899;
        check_all("R7");
        wr(1, 1'b0, 8'h56);
        vs_pulse(MINW);
        check_all("R7");
    endtask

    task automatic t_fire_write;
        set_mode(2'b01);
        wr(0, 1'b0, 8'h10);
        @(negedge clk);
        vsync_in = 1'b1;
        repeat (MINW + 1) @(negedge clk);
        vsync_in = 1'b0;
        repeat (2) @(negedge clk);
        wr_en = 1'b1; wr_addr = AW'(0); wr_hi = 1'b0; wr_data = 8'h20;
        @(negedge clk);
        wr_en = 1'b0;
        repeat (3) @(negedge clk);
        exp_lvl[0] = 16'h0010;
        check_all("R8");
        vs_pulse(MINW);
        exp_lvl[0] = 16'h0020;
        check_all("R8");
    endtask

    task automatic t_mode_change;
        wr(7, 1'b0, 8'h44);
        set_mode(2'b10);
        vs_pulse(MINW);
        check_all("R9");
        set_mode(2'b01);
        wr(5, 1'b0, 8'h66);
        set_mode(2'b00);
        set_mode(2'b01);
        vs_pulse(MINW);
        check_all("R9");
        set_mode(2'b00);
        wr(7, 1'b0, 8'h55); exp_lvl[7] = 16'h0055;
        check_all("R9");
    endtask

    initial begin
        rst_n = 1'b0; cfg_mode = 2'b00; wr_en = 1'b0; wr_addr = '0;
        wr_hi = 1'b0; wr_data = 8'h00; vsync_in = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_direct();
        t_spare();
        t_frame8();
        t_frame16();
        t_fire_write();
        t_mode_change();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        #2000000;
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog actual running expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule